// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge and End-of-Interrupt Arbiter

This block sits between a bank of interrupt sources and one processor. It keeps two bit vectors indexed by source number. One is the pending set of requests that were accepted for this processor. The other is the set of requests the processor has taken but not yet retired. It also keeps a task-priority threshold that filters new requests and a spurious vector that is returned when an acknowledge finds nothing valid.

The sources' configuration is held outside the block and is presented to it continuously as flat buses: a priority, a vector, a level/edge flag and an activity flag per source. A request names one source. It is accepted into the pending set only when that source's priority beats the threshold.

An acknowledge picks the best pending entry and checks it again against the live activity flag and the threshold. It then returns either the entry's vector or the spurious vector, one cycle later. An end-of-interrupt retires the best in-service entry. It then re-raises the processor line if a pending entry now outranks what remains in service.

The request input is a valid/ready stream. `req_ready` is low in any cycle where `ack_req` or `eoi_req` is high. The source must then hold `req_valid` and `req_id` until a cycle with `req_ready` high. The response has no ready, because it answers a read strobe and lasts exactly one cycle. An end-of-interrupt that arrives together with an acknowledge is dropped.

Top module: `ack_eoi_arbiter`

## Requirements
- R1: After reset, `cpu_irq` is 0, `rsp_valid` is 0, `clr_act` is 0, `req_ready` is 1, `spur_vec` is 0xFF and the task threshold is 0xF, so even a priority-15 request is refused.
- R2: A request is put into the pending set only when the source's priority is strictly greater than the task threshold. A refused request leaves `cpu_irq` unchanged and is never acknowledged.
- R3: An accepted request sets `cpu_irq` when the pending set was empty or its priority is strictly greater than the best pending priority before it was accepted. Otherwise `cpu_irq` keeps its value.
- R4: `rsp_valid` is high for exactly the cycle after each `ack_req`. An acknowledge with an empty pending set returns `spur_vec` and pulses no `clr_act` bit.
- R5: An acknowledge selects the pending entry with the highest live priority. Among equal priorities, the lowest source number wins.
- R6: A valid acknowledge returns the source's vector, moves the entry from the pending set to the in-service set, and pulses its `clr_act` bit only if the source is edge-triggered (`src_level` bit 0).
- R7: If the selected entry is no longer active, or its priority no longer exceeds the threshold, the acknowledge returns `spur_vec`, pulses its `clr_act` bit and removes it from the pending set.
- R8: After any acknowledge, `cpu_irq` equals whether some remaining pending entry's priority exceeds the best in-service priority, with an empty in-service set counting as 0.
- R9: An end-of-interrupt clears the best in-service entry (lowest number on ties). It sets `cpu_irq` if the best pending priority exceeds the best remaining in-service priority. Otherwise `cpu_irq` keeps its value.
- R10: `tpr_wr` loads the threshold and `spur_wr` loads `spur_vec`. Both take effect from the next cycle.
- R11: `req_ready` is low in any cycle with `ack_req` or `eoi_req` high. A request held across such a cycle is accepted in the first cycle with `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_prio | input | NSRC*PW | Live priority per source, source i at bits [i*PW +: PW] |
| src_vec | input | NSRC*VW | Vector per source, source i at bits [i*VW +: VW] |
| src_level | input | NSRC | 1 = level-triggered, 0 = edge-triggered |
| src_active | input | NSRC | Live activity flag per source |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_id | input | IW | Requesting source number |
| ack_req | input | 1 | Acknowledge read strobe |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| tpr_wr | input | 1 | Task threshold write enable |
| tpr_wdata | input | PW | New task threshold |
| spur_wr | input | 1 | Spurious vector write enable |
| spur_wdata | input | VW | New spurious vector |
| cpu_irq | output | 1 | Interrupt line to the processor |
| rsp_valid | output | 1 | Acknowledge response valid |
| rsp_vec | output | VW | Returned vector |
| clr_act | output | NSRC | One-cycle activity-clear pulse back to the sources |
| spur_vec | output | VW | Current spurious vector |

## Verification
Four properties are checked in every cycle:
- the pending set shrinks by exactly one entry per acknowledge that finds it non-empty;
- the in-service set grows only on an acknowledge and shrinks by one on each end-of-interrupt;
- new pending bits appear only after a request;
- at most one `clr_act` bit pulses at a time, and an empty acknowledge returns the spurious vector.

Only the directed scenarios can show the rest:
- the choice among equal priorities;
- the live re-check that turns a stale entry into a spurious answer;
- the exact level of `cpu_irq` after acknowledges and retirements;
- the threshold filtering;
- a request held through back-pressure being taken afterwards.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE,
    OP_REQ,
    OP_ACK,
    OP_EOI
  } op_e;
endpackage

// File: rtl/arb_prio_enc.sv
module arb_prio_enc #(
  parameter int N  = 8,
  parameter int PW = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    mask,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   best
);
  // Strict greater-than keeps the lowest index among equal priorities.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (!found || prio[i*PW +: PW] > best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/ack_eoi_arbiter.sv
module ack_eoi_arbiter
  import arb_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int PW   = 4,
  parameter int VW   = 8,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC*PW-1:0] src_prio,
  input  logic [NSRC*VW-1:0] src_vec,
  input  logic [NSRC-1:0]   src_level,
  input  logic [NSRC-1:0]   src_active,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IW-1:0]     req_id,
  input  logic              ack_req,
  input  logic              eoi_req,
  input  logic              tpr_wr,
  input  logic [PW-1:0]     tpr_wdata,
  input  logic              spur_wr,
  input  logic [VW-1:0]     spur_wdata,
  output logic              cpu_irq,
  output logic              rsp_valid,
  output logic [VW-1:0]     rsp_vec,
  output logic [NSRC-1:0]   clr_act,
  output logic [VW-1:0]     spur_vec
);
  logic [NSRC-1:0] raised_q, svc_q;
  logic [PW-1:0]   tpr_q;
  logic [PW-1:0]   prio_a [NSRC];
  logic [VW-1:0]   vec_a  [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign prio_a[g] = src_prio[g*PW +: PW];
    assign vec_a[g]  = src_vec[g*VW +: VW];
  end

  // Three searches: pending set, in-service set, in-service set minus its best.
  logic          r_found, s_found, m_found;
  logic [IW-1:0] r_idx, s_idx, m_idx;
  logic [PW-1:0] r_prio, s_prio, m_prio;
  logic [NSRC-1:0] svc_rest;

  arb_prio_enc #(.N(NSRC), .PW(PW), .IW(IW)) raised_enc_i (
    .mask(raised_q), .prio(src_prio), .found(r_found), .idx(r_idx), .best(r_prio));
  arb_prio_enc #(.N(NSRC), .PW(PW), .IW(IW)) svc_enc_i (
    .mask(svc_q), .prio(src_prio), .found(s_found), .idx(s_idx), .best(s_prio));

  assign svc_rest = svc_q & ~(s_found ? (NSRC'(1) << s_idx) : '0);

  arb_prio_enc #(.N(NSRC), .PW(PW), .IW(IW)) rest_enc_i (
    .mask(svc_rest), .prio(src_prio), .found(m_found), .idx(m_idx), .best(m_prio));

  op_e op;
  always_comb begin
    if (ack_req)                op = OP_ACK;
    else if (eoi_req)           op = OP_EOI;
    else if (req_valid)         op = OP_REQ;
    else                        op = OP_IDLE;
  end
  assign req_ready = !(ack_req || eoi_req);

  // Acknowledge evaluation
  logic            ack_ok;
  logic [NSRC-1:0] sel_mask, raised_after;
  logic [PW-1:0]   svc_best_after;
  logic            above_after;
  always_comb begin
    sel_mask       = r_found ? (NSRC'(1) << r_idx) : '0;
    ack_ok         = r_found && src_active[r_idx] && (prio_a[r_idx] > tpr_q);
    raised_after   = raised_q & ~sel_mask;
    svc_best_after = s_found ? s_prio : '0;
    if (ack_ok && (!s_found || prio_a[r_idx] > s_prio))
      svc_best_after = prio_a[r_idx];
    above_after = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (raised_after[i] && (prio_a[i] > svc_best_after)) above_after = 1'b1;
  end

  logic accept, eoi_raise;
  assign accept    = (op == OP_REQ) && (prio_a[req_id] > tpr_q) && !raised_q[req_id];
  assign eoi_raise = r_found && (!m_found || r_prio > m_prio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raised_q  <= '0;
      svc_q     <= '0;
      tpr_q     <= '1;
      spur_vec  <= '1;
      cpu_irq   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_vec   <= '0;
      clr_act   <= '0;
    end else begin
      rsp_valid <= ack_req;
      clr_act   <= '0;
      if (tpr_wr)  tpr_q    <= tpr_wdata;
      if (spur_wr) spur_vec <= spur_wdata;
      case (op)
        OP_ACK: begin
          rsp_vec  <= ack_ok ? vec_a[r_idx] : spur_vec;
          raised_q <= raised_after;
          if (ack_ok) svc_q[r_idx] <= 1'b1;
          if (r_found && (!ack_ok || !src_level[r_idx])) clr_act <= sel_mask;
          cpu_irq <= above_after;
        end
        OP_EOI: begin
          svc_q <= svc_rest;
          if (eoi_raise) cpu_irq <= 1'b1;
        end
        OP_REQ: begin
          if (accept) begin
            raised_q[req_id] <= 1'b1;
            if (!r_found || prio_a[req_id] > r_prio) cpu_irq <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R5
  ack_shrinks_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && raised_q != '0) |=> ($countones(raised_q) == $countones($past(raised_q)) - 1));
  // R9
  eoi_shrinks_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !ack_req && svc_q != '0) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));
  // R6
  svc_grows_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((svc_q & ~$past(svc_q)) != '0) |-> $past(ack_req));
  // R2
  raised_grows_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raised_q & ~$past(raised_q)) != '0) |-> $past(req_valid));
  // R7
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_act));
  // R4
  empty_ack_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && raised_q == '0) |=> (rsp_valid && rsp_vec == $past(spur_vec) && clr_act == '0));
endmodule

// File: tb/ack_eoi_arbiter_tb_top.sv
module ack_eoi_arbiter_tb_top;
  localparam int NSRC = 8, PW = 4, VW = 8, IW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [PW-1:0] prio_a [NSRC];
  logic [NSRC*PW-1:0] src_prio;
  logic [NSRC*VW-1:0] src_vec;
  logic [NSRC-1:0] src_level, src_active;
  logic req_valid, req_ready, ack_req, eoi_req, tpr_wr, spur_wr;
  logic [IW-1:0] req_id;
  logic [PW-1:0] tpr_wdata;
  logic [VW-1:0] spur_wdata, rsp_vec, spur_vec;
  logic cpu_irq, rsp_valid;
  logic [NSRC-1:0] clr_act;

  always_comb
    for (int i = 0; i < NSRC; i++) begin
      src_prio[i*PW +: PW] = prio_a[i];
      src_vec[i*VW +: VW]  = VW'(8'h40 + i);
    end

  ack_eoi_arbiter #(.NSRC(NSRC), .PW(PW), .VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_prio(src_prio), .src_vec(src_vec),
    .src_level(src_level), .src_active(src_active), .req_valid(req_valid),
    .req_ready(req_ready), .req_id(req_id), .ack_req(ack_req), .eoi_req(eoi_req),
    .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .spur_wr(spur_wr), .spur_wdata(spur_wdata),
    .cpu_irq(cpu_irq), .rsp_valid(rsp_valid), .rsp_vec(rsp_vec), .clr_act(clr_act),
    .spur_vec(spur_vec));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(int id, logic exp_irq, string tag);
    @(negedge clk); req_valid = 1'b1; req_id = IW'(id);
    @(negedge clk); req_valid = 1'b0;
    chk(tag, cpu_irq, exp_irq);
  endtask

  task automatic do_ack(logic [7:0] ev, logic [7:0] ec, logic ei, string tag);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0;
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " vec"}, rsp_vec, ev);
    chk({tag, " clr"}, clr_act, ec);
    chk({tag, " irq"}, cpu_irq, ei);
  endtask

  task automatic do_eoi(logic ei, string tag);
    @(negedge clk); eoi_req = 1'b1;
    @(negedge clk); eoi_req = 1'b0;
    chk(tag, cpu_irq, ei);
  endtask

  task automatic set_tpr(logic [3:0] v);
    @(negedge clk); tpr_wr = 1'b1; tpr_wdata = v;
    @(negedge clk); tpr_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", cpu_irq, 0);
    chk("R1 spur", spur_vec, 8'hFF);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 clr", clr_act, 0);
    chk("R1 ready", req_ready, 1);
    do_req(6, 0, "R1 prio15 refused at tpr F");
    do_ack(8'hFF, 0, 0, "R4 empty ack after reset");
  endtask

  task automatic t_main;
    set_tpr(4'd3); // R10
    do_req(3, 0, "R2 prio2 below tpr3");
    do_req(0, 1, "R3 first accept raises");
    do_req(2, 1, "R3 higher keeps high");
    do_req(1, 1, "R3 equal prio");
    do_ack(8'h41, 8'h00, 0, "R5 tie lowest index level R6 R8");
    do_req(5, 0, "R3 not above best stays low");
    do_ack(8'h42, 8'h04, 0, "R6 edge clr");
    do_eoi(0, "R9 remaining svc 7");
    do_eoi(1, "R9 svc empty reraise");
    do_ack(8'h45, 8'h20, 0, "R5 R8 prio6");
    do_eoi(1, "R9 reraise prio5");
    do_ack(8'h40, 8'h01, 0, "R6 s0");
    @(negedge clk); spur_wr = 1'b1; spur_wdata = 8'h3C;
    @(negedge clk); spur_wr = 1'b0;
    chk("R10 spur write", spur_vec, 8'h3C);
    do_ack(8'h3C, 0, 0, "R4 empty ack new spur");
    do_eoi(0, "R9 all empty");
  endtask

  task automatic t_recheck;
    do_req(0, 1, "R3 s0");
    do_req(4, 1, "R3 s4");
    src_active[4] = 1'b0;
    do_ack(8'h3C, 8'h10, 1, "R7 inactive R8 keep high");
    src_active[4] = 1'b1;
    do_ack(8'h40, 8'h01, 0, "R5 s0 after stale drop");
    do_req(5, 1, "R3 s5");
    set_tpr(4'd7);
    do_ack(8'h3C, 8'h20, 0, "R7 prio under tpr");
    do_eoi(0, "R9 clear s0");
    set_tpr(4'd3);
  endtask

  task automatic t_backpressure;
    @(negedge clk); req_valid = 1'b1; req_id = 3'd4; ack_req = 1'b1;
    #1 chk("R11 ready low on ack", req_ready, 0);
    @(negedge clk); ack_req = 1'b0;
    chk("R11 held req not taken", cpu_irq, 0);
    chk("R11 spur rsp", rsp_vec, 8'h3C);
    #1 chk("R11 ready back", req_ready, 1);
    @(negedge clk); req_valid = 1'b0;
    chk("R11 held req accepted", cpu_irq, 1);
    do_ack(8'h44, 8'h10, 0, "R11 ack held req");
    do_eoi(0, "R9 final");
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_id = 0; ack_req = 0; eoi_req = 0;
    tpr_wr = 0; tpr_wdata = 0; spur_wr = 0; spur_wdata = 0;
    prio_a[0] = 4'd5; prio_a[1] = 4'd7; prio_a[2] = 4'd7; prio_a[3] = 4'd2;
    prio_a[4] = 4'd9; prio_a[5] = 4'd6; prio_a[6] = 4'd15; prio_a[7] = 4'd1;
    src_level = 8'b0000_0010;
    src_active = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_main();
    t_recheck();
    t_backpressure();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule